// File: doc/BRIEF.md
# Pause Quanta Receive Timer

This block handles the receive half of full-duplex pause flow control in a MAC. The receive parser reports a valid pause frame as a one-cycle strobe that carries the frame's 16-bit quanta value. That value loads a down-counter. Each quantum lasts 512 bit times. A prescaler counts bit-time ticks and takes one off the counter at the end of every quantum.

While the counter is non-zero, the block asks the transmit side to hold back new frames. The hold only rises while the transmitter is idle, so a frame already on the wire is allowed to finish. A pause frame that arrives during a pause replaces the remaining count. A quanta value of zero ends the pause at once.

The block never gates reception. Pause strobes take effect only while the link is in full-duplex mode.

Top module: `pause_rx_timer`

## Requirements
- R1: After reset, `pause_count` is 0 and `tx_hold` is 0.
- R2: A `pause_vld` pulse while `full_duplex` is 1 sets `pause_count` to `pause_quanta` at the clock edge that samples the pulse.
- R3: While `pause_count` is non-zero, it falls by exactly one after every 512 `bit_tick` pulses counted since the last load. Cycles without `bit_tick` do not advance the prescaler.
- R4: A new pause pulse while counting replaces the remaining count with the new value, without adding to it. It also restarts the 512-tick prescaler from zero.
- R5: A pause pulse with quanta 0 sets `pause_count` to 0 at once, and `tx_hold` falls one cycle later.
- R6: `tx_hold` becomes 1 only one cycle after a cycle in which `pause_count` was non-zero and `tx_busy` was 0. While `tx_busy` stays 1, `tx_hold` stays 0 even if a pause is pending.
- R7: Once `tx_hold` is 1, it stays 1 for as long as `pause_count` is non-zero, whatever `tx_busy` does. It falls one cycle after `pause_count` reads 0.
- R8: While `full_duplex` is 0, pause pulses are ignored and `pause_count` is forced to 0 at the next edge.
- R9: A `pause_count` of 0 never wraps: `bit_tick` pulses leave it at 0.
- R10: If a pause pulse coincides with the tick that ends a quantum, the load wins. `pause_count` takes the new value with no decrement applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 when the link is in full-duplex mode |
| pause_vld | input | 1 | One-cycle strobe: a valid pause frame was received |
| pause_quanta | input | 16 | Pause length in quanta, valid with `pause_vld` |
| bit_tick | input | 1 | One pulse per bit time on the line |
| tx_busy | input | 1 | 1 while the transmitter is sending a frame |
| tx_hold | output | 1 | 1 forbids the transmitter from starting a new frame |
| pause_count | output | 16 | Quanta remaining in the current pause |

## Verification
A prescaler that runs off its 512-tick period would show up on `pause_count` at the first quantum boundary after a load. The count would step early or late by a number of cycles the scoreboard catches at once. A count or prescaler that is not cleared on reload would show up within one quantum of the reload. The hold logic is compared every cycle. A hold that revokes an in-progress start, or that lingers after the count reaches zero, is therefore reported in the very cycle it goes wrong.

// File: rtl/pause_rx_pkg.sv
package pause_rx_pkg;
   localparam int unsigned QUANTUM_BITS = 512;

   function automatic int unsigned safe_clog2(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
   parameter int unsigned PRESCALE = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   output logic quantum_done
);
   import pause_rx_pkg::*;
   localparam int unsigned PW = safe_clog2(PRESCALE);
   localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

   generate
      if (PRESCALE < 1) begin : g_bad
         $error("PRESCALE must be at least 1");
      end

      if (PRESCALE == 1) begin : g_direct
         assign quantum_done = run && tick;
      end else begin : g_count
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clear || !run) begin
               pre_q <= '0;
            end else if (tick) begin
               pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
            end
         end

         assign quantum_done = run && tick && (pre_q == LAST);

         a_r3_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
            pre_q <= LAST);
         a_r3_pre_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> pre_q == '0);
      end
   endgenerate
endmodule

// File: rtl/pause_down_counter.sv
module pause_down_counter #(
   parameter int unsigned QW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [QW-1:0] load_val,
   input  logic          dec,
   output logic [QW-1:0] count,
   output logic          active
);
   logic [QW-1:0] cnt_q;

   generate
      if (QW < 1) begin : g_bad
         $error("QW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign count  = cnt_q;
   assign active = (cnt_q != '0);

   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> cnt_q == $past(load_val));
   a_r3_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load && !clr && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
   a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (!dec && !load && !clr) |=> $stable(cnt_q));
   a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !load) |=> cnt_q == '0);
endmodule

// File: rtl/pause_tx_gate.sv
module pause_tx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tx_busy,
   output logic hold
);
   logic hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= 1'b0;
      end else begin
         hold_q <= active && (hold_q || !tx_busy);
      end
   end

   assign hold = hold_q;

   a_r6_rise_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_q && tx_busy) |=> !hold_q);
   a_r7_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && active) |=> hold_q);
   a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !hold_q);
endmodule

// File: rtl/pause_rx_timer.sv
module pause_rx_timer #(
   parameter int unsigned QUANTA_W = 16,
   parameter int unsigned PRESCALE = pause_rx_pkg::QUANTUM_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                full_duplex,
   input  logic                pause_vld,
   input  logic [QUANTA_W-1:0] pause_quanta,
   input  logic                bit_tick,
   input  logic                tx_busy,
   output logic                tx_hold,
   output logic [QUANTA_W-1:0] pause_count
);
   logic load;
   logic clr;
   logic active;
   logic quantum_done;

   generate
      if (QUANTA_W < 1 || QUANTA_W > 32) begin : g_bad_w
         $error("QUANTA_W must lie in 1..32");
      end
   endgenerate

   assign clr  = !full_duplex;
   assign load = pause_vld && full_duplex;

   pause_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear        (load || clr),
      .run          (active),
      .tick         (bit_tick),
      .quantum_done (quantum_done)
   );

   pause_down_counter #(.QW(QUANTA_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .load     (load),
      .load_val (pause_quanta),
      .dec      (quantum_done),
      .count    (pause_count),
      .active   (active)
   );

   pause_tx_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .tx_busy (tx_busy),
      .hold    (tx_hold)
   );

   a_r8_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !full_duplex |=> pause_count == '0);
   a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_vld && full_duplex) |=> pause_count == $past(pause_quanta));
endmodule

// File: tb/pause_rx_timer_tb.sv
module pause_rx_timer_tb;
   localparam int QW = 16;
   localparam int PS = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          full_duplex = 1'b0;
   logic          pause_vld = 1'b0;
   logic [QW-1:0] pause_quanta = '0;
   logic          bit_tick = 1'b0;
   logic          tx_busy = 1'b0;
   logic          tx_hold;
   logic [QW-1:0] pause_count;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   int    exp_cnt_q[$];
   bit    exp_hold_q[$];
   string tag_q[$];

   int ref_cnt = 0;
   int ref_pre = 0;
   bit ref_hold = 1'b0;

   always #2 clk = ~clk;

   pause_rx_timer #(.QUANTA_W(QW), .PRESCALE(PS)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .full_duplex  (full_duplex),
      .pause_vld    (pause_vld),
      .pause_quanta (pause_quanta),
      .bit_tick     (bit_tick),
      .tx_busy      (tx_busy),
      .tx_hold      (tx_hold),
      .pause_count  (pause_count)
   );

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   task automatic step(input bit fd, input bit pv, input int q,
                       input bit tk, input bit busy, input string tag);
      int nc;
      int np;
      bit nh;
      @(negedge clk);
      full_duplex  = fd;
      pause_vld    = pv;
      pause_quanta = QW'(q);
      bit_tick     = tk;
      tx_busy      = busy;
      nh = (ref_cnt != 0) && (ref_hold || !busy);
      nc = ref_cnt;
      np = ref_pre;
      if (!fd) begin
         nc = 0; np = 0;
      end else if (pv) begin
         nc = q; np = 0;
      end else if (ref_cnt == 0) begin
         np = 0;
      end else if (tk) begin
         if (ref_pre == PS - 1) begin
            np = 0; nc = ref_cnt - 1;
         end else begin
            np = ref_pre + 1;
         end
      end
      ref_cnt  = nc;
      ref_pre  = np;
      ref_hold = nh;
      exp_cnt_q.push_back(nc);
      exp_hold_q.push_back(nh);
      tag_q.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_cnt_q.size() > 0) begin
         int    ec;
         bit    eh;
         string t;
         ec = exp_cnt_q.pop_front();
         eh = exp_hold_q.pop_front();
         t  = tag_q.pop_front();
         checks++;
         if (int'(pause_count) != ec || tx_hold != eh) begin
            failures++;
            $display("FAIL %s count=%0d exp=%0d hold=%0d exp=%0d at %0t",
                     t, pause_count, ec, tx_hold, eh, $time);
         end
      end
   end

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      if (pause_count != '0 || tx_hold != 1'b0) begin
         failures++;
         $display("FAIL R1 count=%0d exp=0 hold=%0d exp=0", pause_count, tx_hold);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2 R3 R6 R7: load 2, ticks every cycle, transmitter idle
      step(1, 1, 2, 0, 0, "R2");
      for (int i = 0; i < 1100; i++) step(1, 0, 0, 1, 0, "R3");
      // R9: zero count stays zero under ticks
      for (int i = 0; i < 600; i++) step(1, 0, 0, 1, 0, "R9");

      // R6: pending pause while busy keeps hold low, then rises once idle
      step(1, 1, 3, 1, 1, "R2");
      for (int i = 0; i < 10; i++) step(1, 0, 0, 1, 1, "R6");
      for (int i = 0; i < 5; i++)  step(1, 0, 0, 1, 0, "R6");
      // R7: busy after hold rose does not revoke it
      for (int i = 0; i < 300; i++) step(1, 0, 0, 1, 1, "R7");
      // R4: reload with smaller value restarts prescaler
      step(1, 1, 1, 1, 0, "R4");
      for (int i = 0; i < 520; i++) step(1, 0, 0, 1, i[0], "R4");

      // R3: ticks on alternate cycles only
      step(1, 1, 1, 0, 0, "R2");
      for (int i = 0; i < 1030; i++) step(1, 0, 0, i[0], 0, "R3");

      // R5: zero quanta ends pause immediately
      step(1, 1, 5, 1, 0, "R2");
      for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 0, "R5");
      step(1, 1, 0, 1, 0, "R5");
      for (int i = 0; i < 4; i++) step(1, 0, 0, 1, 0, "R5");

      // R8: half-duplex ignores strobes and clears a running pause
      step(0, 1, 7, 1, 0, "R8");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R8");
      step(1, 1, 9, 1, 0, "R2");
      for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, "R8");
      step(0, 0, 0, 1, 0, "R8");
      for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, "R8");

      // R10: strobe on the quantum-ending tick, load wins
      step(1, 1, 2, 0, 0, "R2");
      for (int i = 0; i < PS - 1; i++) step(1, 0, 0, 1, 0, "R10");
      step(1, 1, 4, 1, 0, "R10");
      for (int i = 0; i < 520; i++) step(1, 0, 0, 1, 0, "R10");
      step(1, 1, 0, 0, 0, "R5");
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R5");

      @(posedge clk);
      #2;
      summary();
   end
endmodule